// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs that software controls through five memory-mapped words. Software places a 5-bit PHY address and a 5-bit register number in a packed address word. For a write it also loads a 16-bit value. It then writes a command word with the launch bit set and an opcode. The controller produces one Clause 22 management frame on the MDC clock and the MDIO data line, and keeps a busy flag raised until the frame has finished.

On a read, the master releases MDIO during the turnaround and the data phase. It shifts in the sixteen bits the PHY returns and keeps them in a read-data word that software fetches once busy has cleared. MDC is derived from the system clock by a parameterised half-period count and stays low between frames. A clause-select bit is stored and read back, but the frame format is always Clause 22.

The controller captures the address and write data when the frame launches. Software may therefore rewrite those words while busy is set without affecting the frame on the wire. A launch written while busy is set is dropped.

Top module: `mdio_master`

## Requirements
- R1: Register word map, by byte offset. 0x40 is the mode word: bit 8 is the clause select, every other bit reads 0. 0x44 is the address word: PHY address in bits 12:8 and register number in bits 4:0, every other bit reads 0. 0x48 is the write-data word: bits 15:0, upper bits read 0. 0x4C is the read-data word: bits 15:0, read only. 0x50 is the command word: it reads only the busy flag in bit 16. Any other offset reads 0.
- R2: A write to 0x50 with bit 8 set while idle starts a frame. Bit 0 of that write is the opcode: 0 selects read and 1 selects write. Busy (bit 16 of 0x50) reads 1 from the cycle after that write for exactly 128*DIV_HALF system clocks, then reads 0.
- R3: MDC is low whenever the block is idle. During a frame it has a period of 2*DIV_HALF system clocks, with its first rising edge DIV_HALF clocks after the frame starts.
- R4: Frame bits 0 to 45 are sent MSB first in this order: 32 ones, start pattern 0 then 1, opcode (1,0 for read; 0,1 for write), the 5-bit PHY address and the 5-bit register number. The first bit is driven from the first cycle of the frame, and each later bit is driven from the falling MDC edge that ends the previous bit.
- R5: On a write frame the master drives the line through all 64 bits. Turnaround is 1 then 0, followed by the 16 write-data bits MSB first.
- R6: On a read frame, output enable is low for bits 46 to 63. MDIO is sampled on the rising MDC edge of each of bits 48 to 63, MSB first. When the frame ends, the 16-bit result is placed in the read-data word (0x4C). A write frame leaves that word unchanged.
- R7: A launch written to 0x50 while busy is set has no effect: the frame in progress and its duration are unchanged.
- R8: The address and write-data words are captured when the frame starts. Rewriting them during a frame changes their readback but not the frame in progress.
- R9: Setting the clause-select bit does not change the frame format: frames remain Clause 22.
- R10: After reset all registers read 0, MDC is low and output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_waddr | input | 8 | Register write byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | 8 | Register read byte offset |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line, output enable |

## Verification
A write frame with mixed address and data bits checks serialisation of every field and that the master keeps driving the line through the turnaround. A read from PHY address 31 with an asymmetric PHY response (0xBEEF) checks the release window, the sampling edge and bit order: a shift or sampling error by one bit would return a different word. A write frame is disturbed by a read launch and by new address and data words while busy. It must go out unchanged and leave the earlier read result in place, which separates latched fields from live register values. A read with the clause bit set and a launch issued on the first idle cycle after a frame cover the mode bit and the restart path.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int AW        = 5;
  localparam int DW        = 16;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  localparam int CMD_GO_BIT   = 8;
  localparam int CMD_BUSY_BIT = 16;
  localparam int MODE_SEL_BIT = 8;

  typedef struct packed {
    logic          is_read;
    logic [AW-1:0] phy;
    logic [AW-1:0] regn;
    logic [DW-1:0] wdata;
  } mdio_req_t;

  function automatic logic [FRAME_LEN-1:0] c22_frame(input mdio_req_t r);
    logic [1:0]    op;
    logic [1:0]    ta;
    logic [DW-1:0] payload;
    op      = r.is_read ? 2'b10 : 2'b01;
    ta      = r.is_read ? 2'b11 : 2'b10;
    payload = r.is_read ? {DW{1'b1}} : r.wdata;
    return {32'hFFFF_FFFF, 2'b01, op, r.phy, r.regn, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick    = run && (cnt == CW'(DIV_HALF - 1));
  assign rise_ev = tick && !mdc;
  assign fall_ev = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  p_mdc_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> mdc);
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  mdio_req_t     req,
  input  logic          mdio_i,
  output logic          busy,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [DW-1:0] rd_word
);
  localparam int BW = $clog2(FRAME_LEN);

  mdio_req_t      req_q;
  logic           active;
  logic [BW-1:0]  bitidx;
  logic [DW-1:0]  shreg;
  logic           rise_ev, fall_ev;
  logic           last_bit, frame_done, accept, sample_now;
  logic [FRAME_LEN-1:0] frame;

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  assign frame      = c22_frame(req_q);
  assign accept     = start && !active;
  assign last_bit   = (bitidx == BW'(FRAME_LEN - 1));
  assign frame_done = active && fall_ev && last_bit;
  assign sample_now = active && rise_ev && req_q.is_read && (bitidx >= BW'(DATA_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      req_q  <= '0;
      bitidx <= '0;
    end else if (accept) begin
      active <= 1'b1;
      req_q  <= req;
      bitidx <= '0;
    end else if (active && fall_ev) begin
      if (last_bit) active <= 1'b0;
      else          bitidx <= bitidx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      rd_word <= '0;
    end else begin
      if (sample_now) shreg <= {shreg[DW-2:0], mdio_i};
      if (frame_done && req_q.is_read) rd_word <= shreg;
    end
  end

  assign busy    = active;
  assign mdio_o  = active ? frame[BW'(FRAME_LEN - 1) - bitidx] : 1'b1;
  assign mdio_oe = active && !(req_q.is_read && (bitidx >= BW'(TA_POS)));

  p_oe_needs_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> active);
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active) |=> $stable(req_q) && active);
  p_bit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fall_ev && !last_bit) |=> bitidx == $past(bitidx) + 1'b1);
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_now) |-> !mdio_oe);
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && req_q.is_read) |=> $stable(rd_word));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wen,
  input  logic [7:0]  bus_waddr,
  input  logic [31:0] bus_wdata,
  input  logic [7:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic          mode_sel;
  logic [AW-1:0] phy_q, regn_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rd_word;
  logic          busy;
  logic          start_req;
  mdio_req_t     req;

  assign start_req = bus_wen && (bus_waddr == OFS_CMD) && bus_wdata[CMD_GO_BIT];
  assign req = '{is_read: !bus_wdata[0], phy: phy_q, regn: regn_q, wdata: wdata_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_sel <= 1'b0;
      phy_q    <= '0;
      regn_q   <= '0;
      wdata_q  <= '0;
    end else if (bus_wen) begin
      case (bus_waddr)
        OFS_MODE:  mode_sel <= bus_wdata[MODE_SEL_BIT];
        OFS_ADDR: begin
          phy_q  <= bus_wdata[8 +: AW];
          regn_q <= bus_wdata[0 +: AW];
        end
        OFS_WDATA: wdata_q <= bus_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      OFS_MODE:  bus_rdata[MODE_SEL_BIT] = mode_sel;
      OFS_ADDR:  begin
        bus_rdata[8 +: AW] = phy_q;
        bus_rdata[0 +: AW] = regn_q;
      end
      OFS_WDATA: bus_rdata[DW-1:0] = wdata_q;
      OFS_RDATA: bus_rdata[DW-1:0] = rd_word;
      OFS_CMD:   bus_rdata[CMD_BUSY_BIT] = busy;
      default: ;
    endcase
  end

  mdio_engine #(.DIV_HALF(DIV_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_req), .req(req), .mdio_i(mdio_i),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_word(rd_word)
  );

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy) |=> busy);
  p_mdc_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int D = 20;
  localparam int FRAME_CYC = 128 * D;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wen = 0;
  logic [7:0]  bus_waddr = 0;
  logic [31:0] bus_wdata = 0;
  logic [7:0]  bus_raddr = 8'h50;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1;

  mdio_master #(.DIV_HALF(D)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  string phase = "R4";

  // reference model state
  bit        busy_m = 0;
  int        k = 0;
  bit        m_rd;
  bit [4:0]  m_phy, m_reg, s_phy, s_reg;
  bit [15:0] m_wd, s_wd, rd_m, phy_resp;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit exp_bit(input int i);
    if (i < 32) return 1;
    if (i == 32) return 0;
    if (i == 33) return 1;
    if (i == 34) return m_rd;
    if (i == 35) return !m_rd;
    if (i <= 40) return m_phy[40 - i];
    if (i <= 45) return m_reg[45 - i];
    if (i == 46) return 1;
    if (i == 47) return 0;
    return m_wd[63 - i];
  endfunction

  // model update at the active edge
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bus_wen && bus_waddr == 8'h50 && bus_wdata[8] && !busy_m) begin
        busy_m = 1; k = 0;
        m_rd = !bus_wdata[0]; m_phy = s_phy; m_reg = s_reg; m_wd = s_wd;
      end else if (busy_m) begin
        k++;
        if (k == FRAME_CYC) begin
          busy_m = 0;
          if (m_rd) rd_m = phy_resp;
        end
      end
      if (bus_wen && bus_waddr == 8'h44) begin
        s_phy = bus_wdata[12:8]; s_reg = bus_wdata[4:0];
      end
      if (bus_wen && bus_waddr == 8'h48) s_wd = bus_wdata[15:0];
    end
  end

  // per-clock comparison, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      int b;
      b = k / (2 * D);
      if (bus_raddr == 8'h50) check("R2 busy", bus_rdata, {15'b0, busy_m, 16'b0});
      check("R3 mdc", mdc, busy_m ? ((k / D) % 2) : 0);
      if (!busy_m) check("R10 oe idle", mdio_oe, 0);
      else if (m_rd && b >= 46) check("R6 oe released", mdio_oe, 0);
      else begin
        check(b >= 46 ? "R5 oe" : "R4 oe", mdio_oe, 1);
        check(b >= 46 ? {"R5 data ", phase} : {"R4 bit ", phase}, mdio_o, exp_bit(b));
      end
    end
  end

  // PHY model drives the line between edges
  always @(negedge clk) begin
    int b;
    b = k / (2 * D);
    if (busy_m && m_rd && b >= 48) mdio_i <= phy_resp[63 - b];
    else if (busy_m && m_rd && b == 47) mdio_i <= 0;
    else mdio_i <= 1;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_raddr = a;
    #1 check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_raddr = 8'h50;
  endtask

  task automatic wait_idle();
    while (busy_m) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R10 mdc reset", mdc, 0);
    check("R10 oe reset", mdio_oe, 0);
    rst_n = 1;
    rd_chk("R10 mode reset", 8'h40, 0);
    rd_chk("R10 addr reset", 8'h44, 0);
    rd_chk("R10 rdata reset", 8'h4C, 0);
    rd_chk("R10 busy reset", 8'h50, 0);

    wr(8'h44, 32'hFFFF_FFFF); rd_chk("R1 addr mask", 8'h44, 32'h1F1F);
    wr(8'h48, 32'hFFFF_FFFF); rd_chk("R1 wdata mask", 8'h48, 32'hFFFF);
    wr(8'h40, 32'hFFFF_FFFF); rd_chk("R1 mode mask", 8'h40, 32'h100);
    rd_chk("R1 unmapped", 8'h54, 0);
    wr(8'h40, 0);             rd_chk("R1 mode clear", 8'h40, 0);

    // write frame
    phase = "R5";
    wr(8'h44, 32'h0511); wr(8'h48, 32'hA53C); wr(8'h50, 32'h101);
    wait_idle();

    // read frame, PHY 31
    phase = "R6"; phy_resp = 16'hBEEF;
    wr(8'h44, 32'h1F00); wr(8'h50, 32'h100);
    wait_idle();
    rd_chk("R6 read result", 8'h4C, 32'hBEEF);

    // write frame disturbed while busy
    phase = "R8";
    wr(8'h44, 32'h001F); wr(8'h48, 32'h0000); wr(8'h50, 32'h101);
    repeat (500) @(negedge clk);
    wr(8'h44, 32'h0303); wr(8'h48, 32'hFFFF); wr(8'h50, 32'h100);
    @(negedge clk);
    check("R7 busy kept", bus_rdata, 32'h1_0000);
    check("R7 still driving", mdio_oe, 1);
    rd_chk("R8 addr readback live", 8'h44, 32'h0303);
    wait_idle();
    rd_chk("R5 rdata untouched", 8'h4C, 32'hBEEF);

    // clause bit set, read still Clause 22
    phase = "R9"; phy_resp = 16'h1234;
    wr(8'h40, 32'h100); wr(8'h44, 32'h0A15); wr(8'h50, 32'h100);
    wait_idle();
    rd_chk("R9 read result", 8'h4C, 32'h1234);

    // back-to-back: launch on first idle cycle
    phase = "R2"; phy_resp = 16'h8001;
    wr(8'h50, 32'h100);
    while (busy_m) @(negedge clk);
    wr(8'h48, 32'h5A5A); wr(8'h50, 32'h101);
    wait_idle();
    rd_chk("R6 msb/lsb result", 8'h4C, 32'h8001);
    rd_chk("R2 idle after frame", 8'h50, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule